// File: doc/BRIEF.md
# Per-thread instruction queue drain to decode

This block sits between instruction fetch and decode in a multi-threaded core. Each hardware thread owns a small in-order instruction queue that fetch fills through its own push port. Every cycle the block moves up to a decode-width number of instructions out of those queues into one output bundle. The bundle carries a valid bit, a thread number and a payload per slot. The payload is opaque to the block.

Fairness between threads comes from the starting point of each cycle's drain. A free-running 16-bit LFSR, reduced modulo the number of active threads, selects which active thread goes first. From there the drain visits threads in ascending index order with wrap-around and takes one instruction per visit. A thread is passed over when it is inactive, held off by decode, being flushed, or out of instructions. Decode holds a thread off with a block pulse, which sets a sticky stall flag, and releases it with an unblock pulse. Flushing a thread empties its queue at once.

Top module: `fetch_queue_drain`

## Requirements
- R1: Each thread queue holds at most Q_DEPTH entries. `full_o[t]` is high exactly when the queue of thread t holds Q_DEPTH entries at the start of the cycle. A push offered while `full_o[t]` is high is dropped, even if entries leave that cycle.
- R2: Instructions of one thread leave in the order they were pushed, and each accepted push leaves at most once.
- R3: At most DEC_W instructions leave per cycle. Valid slots are packed from slot 0 upward, and a valid slot never follows an invalid one.
- R4: A block pulse on `block_i[t]` sets the stall flag of thread t, and an unblock pulse on `unblock_i[t]` clears it. Either pulse takes effect in the cycle it is asserted. A stalled thread sends nothing. Asserting both pulses for one thread in the same cycle is illegal.
- R5: The LFSR resets to 16'hACE1. On every clock edge out of reset it shifts left by one bit, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. In each cycle, k is the current LFSR value modulo the number of set bits in `active_i`. The drain starts at the k-th active thread, counting from 0 in ascending index order.
- R6: Starting at the chosen thread, the drain visits thread indices in ascending order with wrap-around and takes one instruction per visit. It passes over threads that are inactive, stalled, flushed or empty. It stops when DEC_W slots are filled or no eligible instruction remains.
- R7: When `flush_i[t]` is high, thread t sends nothing in that cycle, its push that cycle is dropped, and its queue is empty from the next cycle.
- R8: `busy_o` is high exactly in the cycles in which at least one slot is valid.
- R9: A thread with `active_i[t]` low sends nothing but still accepts pushes. With no active thread, no slot is valid.
- R10: While `rst_ni` is low, all queues are empty, all stall flags are clear, the LFSR holds its seed and no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_i | input | N_THREADS | Threads taking part in the drain |
| push_valid_i | input | N_THREADS | Per-thread push strobe from fetch |
| push_data_i | input | N_THREADS*PAY_W | Per-thread instruction payload |
| full_o | output | N_THREADS | Per-thread queue full |
| block_i | input | N_THREADS | Decode block pulse per thread |
| unblock_i | input | N_THREADS | Decode unblock pulse per thread |
| flush_i | input | N_THREADS | Per-thread queue flush |
| out_valid_o | output | DEC_W | Slot valid bits |
| out_tid_o | output | DEC_W*TID_W | Thread number per slot |
| out_data_o | output | DEC_W*PAY_W | Payload per slot |
| busy_o | output | 1 | At least one instruction sent this cycle |

## Verification
The assertions assume that decode never raises block and unblock for the same thread in one cycle. They also assume that inputs are stable around the active edge. The stimulus respects the first rule: unblock is only driven for threads whose modelled stall flag is set, and only where block is low for that thread. It respects the second by changing every input at the falling edge. Pushes to full queues and pushes during a flush are offered on purpose, because the block must drop them rather than assume they never happen.

// File: rtl/fqd_pkg.sv
package fqd_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/fqd_lfsr.sv
module fqd_lfsr
  import fqd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output lfsr_t state_o
);
  lfsr_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LFSR_SEED;
    else         q <= {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  end

  assign state_o = q;

  // R5
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0);
endmodule

// File: rtl/fqd_queue.sv
module fqd_queue #(
  parameter int DEPTH = 4,
  parameter int PW    = 16,
  parameter int WIN   = 3,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PCW  = $clog2(WIN + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [PW-1:0]           data_i,
  input  logic                    flush_i,
  input  logic [PCW-1:0]          pop_cnt_i,
  output logic [CW-1:0]           cnt_o,
  output logic                    full_o,
  output logic [WIN-1:0][PW-1:0]  win_o
);
  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok;
  logic [AW-1:0] wr_ptr;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !flush_i && !full_o;
  assign wr_ptr  = head_q + AW'(cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + AW'(pop_cnt_i);
      cnt_q  <= cnt_q - CW'(pop_cnt_i) + CW'(push_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  for (genvar g = 0; g < WIN; g++) begin : g_win
    assign win_o[g] = mem[head_q + AW'(g)];
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> (cnt_q <= $past(cnt_q)));
  // R3
  pop_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_cnt_i) <= int'(cnt_q));
  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/fqd_start_pick.sv
module fqd_start_pick
  import fqd_pkg::*;
#(
  parameter int N    = 4,
  localparam int TW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  active_i,
  input  lfsr_t         lfsr_i,
  output logic [TW-1:0] start_o,
  output logic          any_o
);
  always_comb begin
    int ones;
    int k;
    int seen;
    ones    = $countones(active_i);
    k       = (ones == 0) ? 0 : (int'(lfsr_i) % ones);
    seen    = 0;
    start_o = '0;
    for (int t = 0; t < N; t++) begin
      if (active_i[t]) begin
        if (seen == k) start_o = TW'(t);
        seen++;
      end
    end
  end

  assign any_o = |active_i;
endmodule

// File: rtl/fqd_drain_sel.sv
module fqd_drain_sel #(
  parameter int N    = 4,
  parameter int W    = 3,
  parameter int PW   = 16,
  parameter int CW   = 3,
  localparam int TW  = (N > 1) ? $clog2(N) : 1,
  localparam int PCW = $clog2(W + 1)
) (
  input  logic [TW-1:0]               start_i,
  input  logic [N-1:0]                elig_i,
  input  logic [N-1:0][CW-1:0]        cnt_i,
  input  logic [N-1:0][W-1:0][PW-1:0] win_i,
  output logic [W-1:0]                slot_v_o,
  output logic [W-1:0][TW-1:0]        slot_tid_o,
  output logic [W-1:0][PW-1:0]        slot_data_o,
  output logic [N-1:0][PCW-1:0]       pop_cnt_o
);
  // One visit per thread per round; N*W visits cover the worst case of a single eligible thread.
  always_comb begin
    int taken [N];
    int used;
    int t;
    used        = 0;
    slot_v_o    = '0;
    slot_tid_o  = '0;
    slot_data_o = '0;
    for (int i = 0; i < N; i++) taken[i] = 0;
    for (int s = 0; s < N * W; s++) begin
      t = (int'(start_i) + s) % N;
      if (elig_i[t] && (taken[t] < int'(cnt_i[t])) && (used < W)) begin
        slot_v_o[used]    = 1'b1;
        slot_tid_o[used]  = TW'(t);
        slot_data_o[used] = win_i[t][taken[t]];
        taken[t]++;
        used++;
      end
    end
    for (int i = 0; i < N; i++) pop_cnt_o[i] = PCW'(taken[i]);
  end
endmodule

// File: rtl/fetch_queue_drain.sv
module fetch_queue_drain
  import fqd_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int Q_DEPTH   = 4,
  parameter int DEC_W     = 3,
  parameter int PAY_W     = 16,
  localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int CNT_W    = $clog2(Q_DEPTH + 1),
  localparam int POP_W    = $clog2(DEC_W + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_THREADS-1:0]            active_i,
  input  logic [N_THREADS-1:0]            push_valid_i,
  input  logic [N_THREADS-1:0][PAY_W-1:0] push_data_i,
  output logic [N_THREADS-1:0]            full_o,
  input  logic [N_THREADS-1:0]            block_i,
  input  logic [N_THREADS-1:0]            unblock_i,
  input  logic [N_THREADS-1:0]            flush_i,
  output logic [DEC_W-1:0]                out_valid_o,
  output logic [DEC_W-1:0][TID_W-1:0]     out_tid_o,
  output logic [DEC_W-1:0][PAY_W-1:0]     out_data_o,
  output logic                            busy_o
);
  logic [N_THREADS-1:0]                        stall_q, stall_eff, elig;
  logic [N_THREADS-1:0][CNT_W-1:0]             cnt;
  logic [N_THREADS-1:0][POP_W-1:0]             pop_cnt;
  logic [N_THREADS-1:0][DEC_W-1:0][PAY_W-1:0]  win;
  lfsr_t                                       lfsr;
  logic [TID_W-1:0]                            start;
  logic                                        any_act;

  // Pulses act in the cycle they arrive, then persist through stall_q.
  assign stall_eff = (stall_q | block_i) & ~unblock_i;
  assign elig      = active_i & ~stall_eff & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= '0;
    else         stall_q <= stall_eff;
  end

  fqd_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr)
  );

  fqd_start_pick #(.N(N_THREADS)) u_pick (
    .active_i (active_i),
    .lfsr_i   (lfsr),
    .start_o  (start),
    .any_o    (any_act)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_q
    fqd_queue #(.DEPTH(Q_DEPTH), .PW(PAY_W), .WIN(DEC_W)) u_q (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push_valid_i[t]),
      .data_i    (push_data_i[t]),
      .flush_i   (flush_i[t]),
      .pop_cnt_i (pop_cnt[t]),
      .cnt_o     (cnt[t]),
      .full_o    (full_o[t]),
      .win_o     (win[t])
    );
  end

  fqd_drain_sel #(.N(N_THREADS), .W(DEC_W), .PW(PAY_W), .CW(CNT_W)) u_sel (
    .start_i     (start),
    .elig_i      (elig),
    .cnt_i       (cnt),
    .win_i       (win),
    .slot_v_o    (out_valid_o),
    .slot_tid_o  (out_tid_o),
    .slot_data_o (out_data_o),
    .pop_cnt_o   (pop_cnt)
  );

  assign busy_o = |out_valid_o;

  // R4
  blk_unblk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i & unblock_i) == '0);
  // R5
  start_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |-> active_i[start]);

  for (genvar i = 0; i < DEC_W; i++) begin : g_slot_chk
    // R4 R9
    slot_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[i] |-> (active_i[out_tid_o[i]] && !stall_eff[out_tid_o[i]]));
    if (i + 1 < DEC_W) begin : g_pack
      // R3
      slot_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o[i] |-> !out_valid_o[i+1]);
    end
  end
endmodule

// File: tb/fetch_queue_drain_test.sv
`timescale 1ns/1ps
module fetch_queue_drain_test;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int W  = 3;
  localparam int PW = 16;
  localparam int TW = 2;

  // {active, push, block, unblock, flush}, one nibble each
  localparam logic [19:0] TBL [16] = '{
    20'hFF000, 20'hFF000, 20'hFF000, 20'hF0200,
    20'hFF000, 20'h5F000, 20'hF0020, 20'hFF008,
    20'hFF000, 20'hFF000, 20'h0F000, 20'h1F100,
    20'hF0010, 20'hFF000, 20'h30004, 20'hF0000
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] active_i = '0, push_valid_i = '0, block_i = '0, unblock_i = '0, flush_i = '0;
  logic [N-1:0][PW-1:0] push_data_i = '0;
  logic [N-1:0] full_o;
  logic [W-1:0] out_valid_o;
  logic [W-1:0][TW-1:0] out_tid_o;
  logic [W-1:0][PW-1:0] out_data_o;
  logic busy_o;

  always #2 clk = ~clk;

  fetch_queue_drain #(.N_THREADS(N), .Q_DEPTH(D), .DEC_W(W), .PAY_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .active_i(active_i), .push_valid_i(push_valid_i),
    .push_data_i(push_data_i), .full_o(full_o), .block_i(block_i), .unblock_i(unblock_i),
    .flush_i(flush_i), .out_valid_o(out_valid_o), .out_tid_o(out_tid_o),
    .out_data_o(out_data_o), .busy_o(busy_o)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [PW-1:0] mq [N][D];
  int mc [N];
  logic [N-1:0] mstall = '0;
  logic [15:0] mlfsr = 16'hACE1;
  logic [PW-1:0] seq = 16'h0100;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] act, psh, blk, unb, fl, input string tag);
    logic [N-1:0] st_e, el;
    int ones, k, seen, start, pos, used, rem, pre;
    int taken [N];
    logic [PW-1:0] ed [W];
    int et [W];
    active_i = act; push_valid_i = psh; block_i = blk; unblock_i = unb; flush_i = fl;
    for (int t = 0; t < N; t++) push_data_i[t] = seq + PW'(t);
    #1;
    // reference: R4 stall, R5 start, R6 rotation, R7 flush, R9 activity mask
    st_e = (mstall | blk) & ~unb;
    el = act & ~st_e & ~fl;
    ones = $countones(act);
    start = 0;
    if (ones > 0) begin
      k = int'(mlfsr) % ones;
      seen = 0;
      for (int t = 0; t < N; t++) if (act[t]) begin
        if (seen == k) start = t;
        seen++;
      end
    end
    rem = 0;
    for (int t = 0; t < N; t++) begin
      taken[t] = 0;
      if (el[t]) rem += mc[t];
    end
    pos = start; used = 0;
    while (used < W && rem > 0) begin
      if (el[pos] && taken[pos] < mc[pos]) begin
        ed[used] = mq[pos][taken[pos]];
        et[used] = pos;
        taken[pos]++; used++; rem--;
      end
      pos = (pos + 1) % N;
    end
    for (int i = 0; i < W; i++) begin
      if (i < used)
        chk(out_valid_o[i] && out_tid_o[i] == TW'(et[i]) && out_data_o[i] == ed[i],
            {"R6 R2 R3 slot ", tag}, {out_valid_o[i], 13'(out_tid_o[i]), out_data_o[i]},
            {1'b1, 13'(et[i]), ed[i]});
      else
        chk(!out_valid_o[i], {"R3 empty slot ", tag}, 32'(out_valid_o[i]), 32'd0);
    end
    for (int t = 0; t < N; t++)
      chk(full_o[t] == (mc[t] == D), {"R1 full ", tag}, 32'(full_o[t]), 32'(mc[t] == D));
    chk(busy_o == (used > 0), {"R8 busy ", tag}, 32'(busy_o), 32'(used > 0));
    // state update at the coming edge
    for (int t = 0; t < N; t++) begin
      pre = mc[t];
      if (fl[t]) mc[t] = 0;
      else begin
        for (int j = 0; j < pre - taken[t]; j++) mq[t][j] = mq[t][j + taken[t]];
        mc[t] = pre - taken[t];
        if (psh[t] && pre < D) begin
          mq[t][mc[t]] = seq + PW'(t);
          mc[t]++;
        end
      end
    end
    seq += PW'(N);
    mstall = st_e;
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < N; t++) mc[t] = 0;
    active_i = '1; push_valid_i = '1;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset holds everything empty even with inputs driven
    chk(out_valid_o == '0 && !busy_o, "R10 reset outputs", 32'(out_valid_o), 32'd0);
    chk(full_o == '0, "R10 reset full", 32'(full_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // vector table: R2 R5 R6 R4 R7 R9 mixed
    for (int v = 0; v < 16; v++)
      step(TBL[v][19:16], TBL[v][15:12], TBL[v][11:8], TBL[v][7:4], TBL[v][3:0], "table");
    // drain everything out
    repeat (6) step(4'hF, 4'h0, 4'h0, mstall, 4'h0, "drain");

    // R1: fill thread 2 with no active thread (R9), extra push dropped
    repeat (6) step(4'h0, 4'h4, 4'h0, 4'h0, 4'h0, "R1 R9 fill");
    // R3: single thread empties at width W per cycle
    repeat (2) step(4'h4, 4'h0, 4'h0, 4'h0, 4'h0, "R3 width");

    // R4: block thread 0 while others fill, then release
    step(4'hF, 4'hF, 4'h1, 4'h0, 4'h0, "R4 block");
    step(4'hF, 4'hF, 4'h0, 4'h0, 4'h0, "R4 held");
    step(4'hF, 4'h0, 4'h0, 4'h1, 4'h0, "R4 unblock");
    repeat (3) step(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, "R4 drain");

    // R7: flush with a concurrent push
    repeat (3) step(4'h0, 4'h8, 4'h0, 4'h0, 4'h0, "R7 fill");
    step(4'h8, 4'h8, 4'h0, 4'h0, 4'h8, "R7 flush");
    step(4'h8, 4'h0, 4'h0, 4'h0, 4'h0, "R7 after");

    // R5 R6: pseudo-random legal traffic
    for (int c = 0; c < 400; c++) begin
      logic [3:0] a, p, b, u, f;
      a = 4'($urandom);
      p = 4'($urandom);
      b = 4'($urandom) & 4'($urandom) & 4'($urandom);
      u = mstall & ~b & 4'($urandom);
      f = ($urandom % 8 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      step(a, p, b, u, f, "R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule